// File: doc/BRIEF.md
# DMA Channel Interrupt Timing Generator

This block decides when a single DMA channel raises its interrupt request to the processor. It watches a strobe that marks each finished element transfer and keeps the element position and the count of frames still to go. From these it picks the cycles where an interrupt is due. Addresses, data movement, trigger-event selection and interrupt-line sharing are handled elsewhere.

A start strobe, given while the channel is idle, captures the configuration. The configuration is the channel mode (circular auto-buffer or multi-frame block), an enable bit, an interrupt-mode bit, the buffer or frame length and the frame count. A circular run never ends and wraps around the buffer. A multi-frame run stops after its last frame and then waits for the next start.

The controller has three named states:
- ST_IDLE: no run in progress.
- ST_RING: a circular auto-buffer run is in progress.
- ST_FRAMES: a multi-frame run is in progress.

The transitions are:
- ST_IDLE to ST_RING on start with mode = 1.
- ST_IDLE to ST_FRAMES on start with mode = 0.
- ST_FRAMES to ST_IDLE on the element strobe that ends the final frame.
- Any state to ST_IDLE on reset.
- All other cycles hold the state.

Top module: `dma_irq_gen`

## Requirements
- R1: With the enable bit captured as 0, irq stays 0 for the whole run, whatever the mode and interrupt-mode bit.
- R2: In auto-buffer mode (cfg_mode = 1) with interrupt mode 0, irq pulses on every strobe that fills the buffer. That is every cfg_len-th strobe counted from start. The position then wraps to zero and the run continues.
- R3: In auto-buffer mode with interrupt mode 1, irq also pulses on the strobe that reaches floor(cfg_len/2) elements in each pass. This half-point pulse is absent when floor(cfg_len/2) is 0.
- R4: In multi-frame mode (cfg_mode = 0), the 8-bit frame field F gives F+1 frames of cfg_len elements each. With interrupt mode 0, irq pulses only on the strobe that ends the final frame.
- R5: In multi-frame mode with interrupt mode 1, irq pulses on the strobe that ends each frame. At the final frame the frame end and the block end give a single one-cycle pulse.
- R6: irq is high for exactly the one cycle after the clock edge at which the qualifying elem_done is sampled.
- R7: After the final frame, active drops to 0 and element strobes cause no irq. A later start begins a new block.
- R8: A start while active = 1 is ignored. Configuration inputs are used only at the start that begins a run.
- R9: A synchronous reset forces irq and active to 0 from the next cycle. Strobes then cause no irq until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle; captures configuration |
| elem_done | input | 1 | One element transfer finished this cycle |
| cfg_mode | input | 1 | 1 = circular auto-buffer, 0 = multi-frame |
| cfg_ien | input | 1 | Interrupt enable |
| cfg_imode | input | 1 | Interrupt mode: 1 adds half-buffer or per-frame pulses |
| cfg_len | input | LEN_W | Buffer or frame length in elements (0 acts as 1) |
| cfg_frames | input | FRM_W | Frames after the first (multi-frame mode) |
| irq | output | 1 | One-cycle interrupt request pulse |
| active | output | 1 | A run is in progress |

## Verification
The bench runs both modes with both interrupt-mode settings. It uses odd lengths, where a wrong half point would land one element early or late, and length 1, where a half-point pulse must not appear. It also uses length 2, where half and full pulses fall on neighbouring strobes.

At the end of a multi-frame block, the bench looks for exactly one pulse. A design that fires frame end and block end separately would stretch irq to two cycles. A design that miscounts frames would stop a frame early or never go idle.

Restart while running, strobes while idle and reset in mid-run are each checked at irq and active. A design that reloaded the configuration on any start would shift the wrap point. A design that kept counting after the final frame would emit stray pulses.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RING   = 2'd1,
        ST_FRAMES = 2'd2
    } chan_state_t;
endpackage

// File: rtl/dmairq_count.sv
module dmairq_count #(
    parameter int LEN_W = 8,
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [FRM_W-1:0] cfg_frames,
    output logic             frame_end,
    output logic             half_hit,
    output logic             last_frame
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pos_q;
    logic [FRM_W-1:0] frames_left;
    logic [CW-1:0]    count_next;
    logic [CW-1:0]    half_pt;

    always_comb begin
        count_next = {1'b0, pos_q} + 1'b1;
        half_pt    = {1'b0, len_q >> 1};
        frame_end  = step && (count_next >= {1'b0, len_q});
        half_hit   = step && (half_pt != '0) && (count_next == half_pt);
        last_frame = (frames_left == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q       <= '0;
            pos_q       <= '0;
            frames_left <= '0;
        end else if (load) begin
            len_q       <= cfg_len;
            pos_q       <= '0;
            frames_left <= cfg_frames;
        end else if (step) begin
            if (frame_end) begin
                pos_q <= '0;
                if (!last_frame)
                    frames_left <= frames_left - 1'b1;
            end else begin
                pos_q <= count_next[LEN_W-1:0];
            end
        end
    end

    // R3
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        half_hit |-> (len_q >= 2));

    // R4
    frame_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !last_frame && !load) |=> (frames_left == $past(frames_left) - 1'b1));
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic elem_done,
    input  logic cfg_mode,
    input  logic cfg_ien,
    input  logic cfg_imode,
    input  logic frame_end,
    input  logic half_hit,
    input  logic last_frame,
    output logic load,
    output logic step,
    output logic irq,
    output logic active
);
    chan_state_t state_q, state_d;
    logic ien_q, imode_q;
    logic event_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        event_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = cfg_mode ? ST_RING : ST_FRAMES;
                end
            end
            ST_RING: begin
                event_d = frame_end || (imode_q && half_hit);
            end
            ST_FRAMES: begin
                event_d = frame_end && (imode_q || last_frame);
                if (frame_end && last_frame)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        step = elem_done && (state_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            ien_q   <= 1'b0;
            imode_q <= 1'b0;
        end else begin
            irq <= event_d && ien_q;
            if (load) begin
                ien_q   <= cfg_ien;
                imode_q <= cfg_imode;
            end
        end
    end

    assign active = (state_q != ST_IDLE);

    // R6
    irq_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(elem_done));

    // R1
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien_q);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !irq);
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen #(
    parameter int LEN_W = 8,
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             elem_done,
    input  logic             cfg_mode,
    input  logic             cfg_ien,
    input  logic             cfg_imode,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [FRM_W-1:0] cfg_frames,
    output logic             irq,
    output logic             active
);
    logic load, step, frame_end, half_hit, last_frame;

    dmairq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .elem_done  (elem_done),
        .cfg_mode   (cfg_mode),
        .cfg_ien    (cfg_ien),
        .cfg_imode  (cfg_imode),
        .frame_end  (frame_end),
        .half_hit   (half_hit),
        .last_frame (last_frame),
        .load       (load),
        .step       (step),
        .irq        (irq),
        .active     (active)
    );

    dmairq_count #(.LEN_W(LEN_W), .FRM_W(FRM_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .cfg_len    (cfg_len),
        .cfg_frames (cfg_frames),
        .frame_end  (frame_end),
        .half_hit   (half_hit),
        .last_frame (last_frame)
    );
endmodule

// File: tb/dma_irq_gen_bench.sv
module dma_irq_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       elem_done = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_ien = 1'b0;
    logic       cfg_imode = 1'b0;
    logic [7:0] cfg_len = '0;
    logic [7:0] cfg_frames = '0;
    logic       irq, active;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dma_irq_gen u_dma_irq_gen (
        .clk(clk), .rst(rst), .start(start), .elem_done(elem_done),
        .cfg_mode(cfg_mode), .cfg_ien(cfg_ien), .cfg_imode(cfg_imode),
        .cfg_len(cfg_len), .cfg_frames(cfg_frames),
        .irq(irq), .active(active)
    );

    // {mode, ien, imode, len[8], frames[8], strobes[5], irq mask[16], active after}
    localparam logic [40:0] VEC [11] = '{
        {1'b1, 1'b1, 1'b0, 8'd4, 8'd0, 5'd12, 16'h0888, 1'b1}, // R2
        {1'b1, 1'b1, 1'b1, 8'd5, 8'd0, 5'd10, 16'h0252, 1'b1}, // R3 odd
        {1'b0, 1'b1, 1'b0, 8'd3, 8'd2, 5'd12, 16'h0100, 1'b0}, // R4
        {1'b0, 1'b1, 1'b1, 8'd3, 8'd2, 5'd12, 16'h0124, 1'b0}, // R5
        {1'b0, 1'b0, 1'b1, 8'd2, 8'd1, 5'd6,  16'h0000, 1'b0}, // R1
        {1'b1, 1'b0, 1'b1, 8'd4, 8'd0, 5'd8,  16'h0000, 1'b1}, // R1
        {1'b0, 1'b1, 1'b1, 8'd1, 8'd3, 5'd6,  16'h000F, 1'b0}, // R5
        {1'b1, 1'b1, 1'b1, 8'd1, 8'd0, 5'd5,  16'h001F, 1'b1}, // R3 len 1
        {1'b1, 1'b1, 1'b1, 8'd2, 8'd0, 5'd6,  16'h003F, 1'b1}, // R3 len 2
        {1'b0, 1'b1, 1'b0, 8'd4, 8'd0, 5'd6,  16'h0008, 1'b0}, // R4 one frame
        {1'b1, 1'b1, 1'b1, 8'd8, 8'd9, 5'd16, 16'hF0F0 & 16'h0000 | 16'h8888, 1'b1} // R3 R8
    };

    task automatic check(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_start(input logic m, input logic e, input logic im,
                            input logic [7:0] l, input logic [7:0] f);
        cfg_mode = m; cfg_ien = e; cfg_imode = im; cfg_len = l; cfg_frames = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic strobe(output logic got);
        elem_done = 1'b1;
        @(negedge clk);
        got = irq;
        elem_done = 1'b0;
        @(negedge clk);
        check("R6 pulse width", irq, 1'b0);
    endtask

    initial begin
        #(5.0 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic g;
        @(negedge clk);
        do_reset();
        check("R9 reset irq", irq, 1'b0);
        check("R9 reset active", active, 1'b0);

        for (int i = 0; i < 11; i++) begin
            logic [40:0] v;
            v = VEC[i];
            do_reset();
            do_start(v[40], v[39], v[38], v[37:30], v[29:22]);
            // change configuration after start: must not matter (R8)
            cfg_len = 8'd3; cfg_mode = ~v[40]; cfg_imode = ~v[38];
            for (int s = 0; s < int'(v[21:17]); s++) begin
                strobe(g);
                check($sformatf("R2/R3/R4/R5 vec%0d strobe%0d", i, s), g, v[16 - 15 + s]);
            end
            check($sformatf("R7 vec%0d active", i), active, v[0]);
        end

        // R7: strobes while idle are ignored
        do_reset();
        for (int s = 0; s < 3; s++) begin
            strobe(g);
            check("R9 idle strobe", g, 1'b0);
        end

        // R8: start while running ignored
        do_reset();
        do_start(1'b1, 1'b1, 1'b0, 8'd4, 8'd0);
        strobe(g); strobe(g);
        do_start(1'b0, 1'b1, 1'b1, 8'd2, 8'd0);
        strobe(g);
        check("R8 busy start third", g, 1'b0);
        strobe(g);
        check("R8 busy start fourth", g, 1'b1);
        check("R8 still ring", active, 1'b1);

        // R7: restart after block end
        do_reset();
        do_start(1'b0, 1'b1, 1'b0, 8'd2, 8'd0);
        strobe(g);
        check("R7 first", g, 1'b0);
        strobe(g);
        check("R7 block end", g, 1'b1);
        check("R7 idle", active, 1'b0);
        do_start(1'b0, 1'b1, 1'b1, 8'd1, 8'd0);
        check("R7 restarted", active, 1'b1);
        strobe(g);
        check("R7 new block irq", g, 1'b1);

        // R9: reset in mid-run
        do_reset();
        do_start(1'b1, 1'b1, 1'b1, 8'd2, 8'd0);
        strobe(g);
        check("R3 half before reset", g, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid reset active", active, 1'b0);
        check("R9 mid reset irq", irq, 1'b0);
        for (int s = 0; s < 2; s++) begin
            strobe(g);
            check("R9 after reset strobe", g, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule